// File: doc/BRIEF.md
# Three-Loop Shared PI Controller

This block runs a discrete-time proportional-integral regulator for three motor-control loops (speed, direct-axis current and quadrature-axis current) on one arithmetic datapath with a single multiplier. Each loop has its own start strobe, done pulse, reference, feedback, gains, integrator and output register. Only one loop is computed at a time. Requests that arrive together, or while the datapath is busy, are held and then served in a fixed order.

A loop's output is clamped to its limits: the speed loop has its own pair, and the two current loops share one pair. When the output clamps, the integrator is pulled back so that it cannot wind up. A disabled loop outputs its initial value and preloads its integrator, so that enabling it again causes no step. A clear input empties every integrator and output, for use when the motor has stopped. The number of multiplier pipeline stages is a parameter, and the sequencer waits for the product after each of the two multiplies.

Top module: `pi_tri_loop`

## Requirements
- R1: Values are signed two's complement with gains in Q1.15. On a start, the block forms e = ref − fb, P = floor(Kp·e / 2^15), ΔI = floor(Ki·e / 2^15), I = I_prev + ΔI and output Y = P + I.
- R2: Y is clamped to [lo, hi]. Loop 0 (speed) uses spd_lo_i/spd_hi_i. Loops 1 (d-axis) and 2 (q-axis) both use cur_lo_i/cur_hi_i.
- R3: When Y clamps at a limit L, the stored integrator becomes L − P instead of I.
- R4: Each computation produces exactly one done_o bit, in bit position equal to the loop index, high for exactly one cycle. At most one done bit is high at a time.
- R5: While a loop's enable is low (spd_en_i for loop 0, cur_en_i for loops 1 and 2), its output follows init_i of that loop with one cycle of delay.
- R6: Start pulses are held as pending until served. Among pending loops, the lowest index (speed, then d, then q) is served next, including a speed request that arrives while another loop is being computed.
- R7: A start on a disabled loop outputs the loop's init value, pulses done and sets the integrator to init − P, so a later enabled computation with ΔI = 0 and the same error reproduces the init value.
- R8: A one-cycle clr_i pulse zeroes all integrators and outputs on the next cycle, drops pending requests and aborts any computation without a done pulse.
- R9: After reset, every output and every done bit is zero.
- R10: The difference ref − fb saturates to the 16-bit signed range before it is multiplied.
- R11: With MUL_LAT multiplier stages, done_o rises 2·MUL_LAT+4 clock edges after the edge that samples the start of an idle loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Clear all integrators, outputs and pending requests |
| spd_en_i | input | 1 | Enable of the speed loop (0 = output follows init) |
| cur_en_i | input | 1 | Enable of both current loops |
| start_i | input | 3 | Start strobe per loop (bit 0 speed, 1 d, 2 q) |
| ref_i | input | 3×DW | Reference per loop |
| fb_i | input | 3×DW | Feedback per loop |
| kp_i | input | 3×DW | Proportional gain per loop, Q1.15 |
| ki_i | input | 3×DW | Integral gain per loop, Q1.15 |
| init_i | input | 3×DW | Initial/bypass value per loop |
| spd_hi_i | input | DW | Upper output limit, speed loop |
| spd_lo_i | input | DW | Lower output limit, speed loop |
| cur_hi_i | input | DW | Upper output limit, both current loops |
| cur_lo_i | input | DW | Lower output limit, both current loops |
| done_o | output | 3 | One-cycle completion pulse per loop |
| y_o | output | 3×DW | Registered output per loop |

## Verification
The bench goes after integrator windup: it drives a loop into its limit and then reverses the error. A design that kept summing past the clamp would come back late and miss the expected value. It drives extreme reference and feedback values, which a wrapping subtractor would turn into an error of the wrong sign. It raises starts together and during a busy computation, so that a wrong priority or a lost pending bit shows up as a wrong done order or a hang. It runs disabled-to-enabled transitions, where a missing integrator preload would show as a step in the output. A long seeded sweep compares each result against the fixed-point arithmetic in the requirements, and also checks the exact done latency.

// File: rtl/pi_share_pkg.sv
package pi_share_pkg;
  localparam int NLOOP  = 3;
  localparam int LP_SPD = 0;
  localparam int LP_ID  = 1;
  localparam int LP_IQ  = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MULP,
    ST_MULI,
    ST_UPD
  } seq_st_t;
endpackage

// File: rtl/pi_mul.sv
module pi_mul #(
  parameter int DW  = 16,
  parameter int LAT = 2
) (
  input  logic                   clk,
  input  logic signed [DW-1:0]   a_i,
  input  logic signed [DW-1:0]   b_i,
  output logic signed [2*DW-1:0] p_o
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] stg [LAT];

  always_ff @(posedge clk) begin
    stg[0] <= a_i * b_i;
    for (int j = LAT - 1; j > 0; j--) stg[j] <= stg[j-1];
  end

  assign p_o = stg[LAT-1];
endmodule

// File: rtl/pi_arb.sv
module pi_arb #(
  parameter int N  = 3,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic [N-1:0]  req_i,
  input  logic          take_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] pend;
  logic [N-1:0] mask;

  always_comb begin
    any_o = |pend;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) if (pend[k]) idx_o = IW'(k);
  end

  assign mask = take_i ? (N'(1) << idx_o) : '0;

  always_ff @(posedge clk) begin
    if (rst || clr_i) pend <= '0;
    else              pend <= (pend & ~mask) | req_i;
  end

  // R6: a pending request survives until it is taken or cleared
  p_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !take_i) |=> ((pend & $past(pend)) == $past(pend)));

  // R6: the speed request wins whenever it is pending at a grant
  p_prio_r6: assert property (@(posedge clk) disable iff (rst)
    (take_i && pend[0]) |-> (idx_o == '0));

  // R8: clear empties every pending request
  p_clr_pend_r8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (pend == '0));
endmodule

// File: rtl/pi_tri_loop.sv
module pi_tri_loop
  import pi_share_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 32,
  parameter int MUL_LAT = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr_i,
  input  logic                       spd_en_i,
  input  logic                       cur_en_i,
  input  logic [NLOOP-1:0]           start_i,
  input  logic [NLOOP-1:0][DW-1:0]   ref_i,
  input  logic [NLOOP-1:0][DW-1:0]   fb_i,
  input  logic [NLOOP-1:0][DW-1:0]   kp_i,
  input  logic [NLOOP-1:0][DW-1:0]   ki_i,
  input  logic [NLOOP-1:0][DW-1:0]   init_i,
  input  logic [DW-1:0]              spd_hi_i,
  input  logic [DW-1:0]              spd_lo_i,
  input  logic [DW-1:0]              cur_hi_i,
  input  logic [DW-1:0]              cur_lo_i,
  output logic [NLOOP-1:0]           done_o,
  output logic [NLOOP-1:0][DW-1:0]   y_o
);
  localparam int FRAC = DW - 1;
  localparam int PW   = 2 * DW;
  localparam int IW   = $clog2(NLOOP);
  localparam int CW   = $clog2(MUL_LAT + 1);
  localparam logic signed [DW:0] E_MAX = (DW+1)'((1 << (DW-1)) - 1);
  localparam logic signed [DW:0] E_MIN = (DW+1)'(-(1 << (DW-1)));

  seq_st_t              st;
  logic [IW-1:0]        sel;
  logic [CW-1:0]        cnt;
  logic signed [DW-1:0] err;
  logic signed [AW-1:0] pterm, iinc;
  logic signed [AW-1:0] integ [NLOOP];
  logic                 any_req, take;
  logic [IW-1:0]        gidx;
  logic [NLOOP-1:0]     en_v;

  assign en_v = {{(NLOOP-1){cur_en_i}}, spd_en_i};
  assign take = (st == ST_IDLE) && any_req;

  pi_arb #(.N(NLOOP), .IW(IW)) u_arb (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr_i),
    .req_i  (start_i),
    .take_i (take),
    .any_o  (any_req),
    .idx_o  (gidx)
  );

  // Saturated error of the loop about to be granted
  logic signed [DW:0]   diff;
  logic signed [DW-1:0] err_sat;
  always_comb begin
    diff = (DW+1)'($signed(ref_i[gidx])) - (DW+1)'($signed(fb_i[gidx]));
    if (diff > E_MAX)      err_sat = E_MAX[DW-1:0];
    else if (diff < E_MIN) err_sat = E_MIN[DW-1:0];
    else                   err_sat = diff[DW-1:0];
  end

  // Single shared multiplier: Kp in the first pass, Ki in the second
  logic signed [DW-1:0] mul_a;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_q;
  assign mul_a  = (st == ST_MULI) ? $signed(ki_i[sel]) : $signed(kp_i[sel]);
  assign prod_q = AW'(prod >>> FRAC);

  pi_mul #(.DW(DW), .LAT(MUL_LAT)) u_mul (
    .clk (clk),
    .a_i (mul_a),
    .b_i (err),
    .p_o (prod)
  );

  // Update, clamp, anti-windup and bypass
  logic signed [AW-1:0] lim_hi, lim_lo, isum, ysum, init_w, y_new, i_new;
  logic                 en_sel;
  always_comb begin
    lim_hi = (sel == IW'(LP_SPD)) ? AW'($signed(spd_hi_i)) : AW'($signed(cur_hi_i));
    lim_lo = (sel == IW'(LP_SPD)) ? AW'($signed(spd_lo_i)) : AW'($signed(cur_lo_i));
    en_sel = en_v[sel];
    init_w = AW'($signed(init_i[sel]));
    isum   = integ[sel] + iinc;
    ysum   = pterm + isum;
    if (!en_sel) begin
      y_new = init_w;
      i_new = init_w - pterm;
    end else if (ysum > lim_hi) begin
      y_new = lim_hi;
      i_new = lim_hi - pterm;
    end else if (ysum < lim_lo) begin
      y_new = lim_lo;
      i_new = lim_lo - pterm;
    end else begin
      y_new = ysum;
      i_new = isum;
    end
  end

  // Sequencer
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      st    <= ST_IDLE;
      sel   <= '0;
      cnt   <= '0;
      err   <= '0;
      pterm <= '0;
      iinc  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (any_req) begin
          sel <= gidx;
          err <= err_sat;
          cnt <= '0;
          st  <= ST_MULP;
        end
        ST_MULP: if (cnt == CW'(MUL_LAT)) begin
          pterm <= prod_q;
          cnt   <= '0;
          st    <= ST_MULI;
        end else cnt <= cnt + 1'b1;
        ST_MULI: if (cnt == CW'(MUL_LAT)) begin
          iinc <= prod_q;
          cnt  <= '0;
          st   <= ST_UPD;
        end else cnt <= cnt + 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Per-loop state and registered outputs
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      done_o <= '0;
      for (int k = 0; k < NLOOP; k++) begin
        integ[k] <= '0;
        y_o[k]   <= '0;
      end
    end else begin
      done_o <= (st == ST_UPD) ? (NLOOP'(1) << sel) : '0;
      for (int k = 0; k < NLOOP; k++) begin
        if (st == ST_UPD && sel == IW'(k)) begin
          integ[k] <= i_new;
          y_o[k]   <= y_new[DW-1:0];
        end else if (!en_v[k]) begin
          y_o[k] <= init_i[k];
        end
      end
    end
  end

  // R4: never two loops completing together
  p_one_done_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done_o));

  // R4: every done is a single-cycle pulse
  for (genvar g = 0; g < NLOOP; g++) begin : g_pulse
    p_pulse_r4: assert property (@(posedge clk) disable iff (rst)
      done_o[g] |=> !done_o[g]);
  end

  // R2: an enabled speed result lies inside the speed limits
  p_clamp_spd_r2: assert property (@(posedge clk) disable iff (rst)
    (done_o[LP_SPD] && $past(spd_en_i)) |->
      ($signed(y_o[LP_SPD]) <= $signed($past(spd_hi_i)) &&
       $signed(y_o[LP_SPD]) >= $signed($past(spd_lo_i))));

  // R2: an enabled q-axis result lies inside the shared current limits
  p_clamp_iq_r2: assert property (@(posedge clk) disable iff (rst)
    (done_o[LP_IQ] && $past(cur_en_i)) |->
      ($signed(y_o[LP_IQ]) <= $signed($past(cur_hi_i)) &&
       $signed(y_o[LP_IQ]) >= $signed($past(cur_lo_i))));

  // R5: a disabled speed loop follows its init value one cycle later
  p_bypass_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clr_i) && !$past(spd_en_i)) |->
      (y_o[LP_SPD] == $past(init_i[LP_SPD])));

  // R8: clear aborts without a completion pulse
  p_clr_done_r8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (done_o == '0));
endmodule

// File: tb/pi_tri_loop_bench.sv
`timescale 1ns/1ps
module pi_tri_loop_bench;
  localparam int LAT = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             clr_i = 1'b0;
  logic             spd_en_i = 1'b1;
  logic             cur_en_i = 1'b1;
  logic [2:0]       start_i = '0;
  logic [2:0][15:0] ref_i = '0;
  logic [2:0][15:0] fb_i = '0;
  logic [2:0][15:0] kp_i = '0;
  logic [2:0][15:0] ki_i = '0;
  logic [2:0][15:0] init_i = '0;
  logic [15:0]      spd_hi_i = 16'd20000;
  logic [15:0]      spd_lo_i = -16'sd20000;
  logic [15:0]      cur_hi_i = 16'd15000;
  logic [15:0]      cur_lo_i = -16'sd12000;
  logic [2:0]       done_o;
  logic [2:0][15:0] y_o;

  int vecs = 0;
  int miss = 0;
  longint m_int [3];
  logic [31:0] seed = 32'h1ACE_B00C;

  always #10 clk = ~clk;

  pi_tri_loop #(.DW(16), .AW(32), .MUL_LAT(LAT)) u_pi_tri_loop (
    .clk(clk), .rst(rst), .clr_i(clr_i), .spd_en_i(spd_en_i), .cur_en_i(cur_en_i),
    .start_i(start_i), .ref_i(ref_i), .fb_i(fb_i), .kp_i(kp_i), .ki_i(ki_i),
    .init_i(init_i), .spd_hi_i(spd_hi_i), .spd_lo_i(spd_lo_i),
    .cur_hi_i(cur_hi_i), .cur_lo_i(cur_lo_i), .done_o(done_o), .y_o(y_o)
  );

  function automatic longint sx(logic [15:0] v);
    return longint'($signed(v));
  endfunction

  function automatic logic [31:0] nxt();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // Expected result of one computation on loop ch; updates the bench integrator
  function automatic longint model(int ch);
    longint e, p, di, hi, lo, isum, ys, y;
    bit en;
    e = sx(ref_i[ch]) - sx(fb_i[ch]);
    if (e > 32767) e = 32767;
    if (e < -32768) e = -32768;
    p  = (sx(kp_i[ch]) * e) >>> 15;
    di = (sx(ki_i[ch]) * e) >>> 15;
    en = (ch == 0) ? spd_en_i : cur_en_i;
    hi = (ch == 0) ? sx(spd_hi_i) : sx(cur_hi_i);
    lo = (ch == 0) ? sx(spd_lo_i) : sx(cur_lo_i);
    if (!en) begin
      y = sx(init_i[ch]);
      m_int[ch] = y - p;
    end else begin
      isum = m_int[ch] + di;
      ys = p + isum;
      if (ys > hi)      begin y = hi; m_int[ch] = hi - p; end
      else if (ys < lo) begin y = lo; m_int[ch] = lo - p; end
      else              begin y = ys; m_int[ch] = isum; end
    end
    return y;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_done(output logic [2:0] dv);
    int n = 0;
    dv = '0;
    while (dv == 0 && n < 100) begin
      @(negedge clk);
      n++;
      dv = done_o;
    end
  endtask

  task automatic run1(int ch, string tag);
    longint ey;
    int n;
    ey = model(ch);
    @(negedge clk) start_i[ch] = 1'b1;
    @(negedge clk) start_i = '0;
    n = 0;
    while (done_o == 0 && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk("R11 latency", n, 2 * LAT + 4);
    chk("R4 done bit", done_o, 1 << ch);
    chk(tag, sx(y_o[ch]), ey);
    @(negedge clk);
    chk("R4 pulse width", done_o, 0);
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr_i = 1'b1;
    @(negedge clk) clr_i = 1'b0;
    for (int k = 0; k < 3; k++) m_int[k] = 0;
  endtask

  initial begin
    #4_000_000;
    miss++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    logic [2:0] dv;
    longint e0, e1, e2;
    for (int k = 0; k < 3; k++) m_int[k] = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    for (int k = 0; k < 3; k++) chk("R9 output after reset", y_o[k], 0);
    chk("R9 done after reset", done_o, 0);

    // R5: bypass follows init
    spd_en_i = 1'b0;
    init_i[0] = 16'd1234;
    @(negedge clk); @(negedge clk);
    chk("R5 bypass value", sx(y_o[0]), 1234);
    init_i[0] = -16'sd777;
    @(negedge clk);
    chk("R5 bypass follows", sx(y_o[0]), -777);
    spd_en_i = 1'b1;
    pulse_clr();

    // R10: error saturation
    spd_hi_i = 16'h7FFF; spd_lo_i = 16'h8000;
    ref_i[0] = 16'h7FFF; fb_i[0] = 16'h8000; kp_i[0] = 16'h7FFF; ki_i[0] = '0;
    run1(0, "R10 saturated error");
    chk("R10 value", sx(y_o[0]), 32766);

    // R3: anti-windup
    pulse_clr();
    spd_hi_i = 16'd1200; spd_lo_i = -16'sd1200;
    ref_i[0] = 16'd1000; fb_i[0] = '0; kp_i[0] = '0; ki_i[0] = 16'h4000;
    run1(0, "R3 ramp"); run1(0, "R3 ramp"); run1(0, "R3 clamp");
    ref_i[0] = -16'sd1000;
    run1(0, "R3 unwind");
    chk("R3 recovery value", sx(y_o[0]), 700);

    // R7: bumpless enable
    cur_en_i = 1'b0;
    init_i[2] = 16'd3000; ref_i[2] = 16'd2000; fb_i[2] = '0;
    kp_i[2] = 16'h2000; ki_i[2] = 16'h1000;
    run1(2, "R7 disabled start");
    cur_en_i = 1'b1;
    ki_i[2] = '0;
    run1(2, "R7 re-enabled");
    chk("R7 no step", sx(y_o[2]), 3000);

    // R6: pending and priority
    spd_hi_i = 16'd20000; spd_lo_i = -16'sd20000;
    ref_i[0] = 16'd300; fb_i[0] = 16'd100; kp_i[0] = 16'h1000; ki_i[0] = 16'h0800;
    ref_i[1] = -16'sd500; fb_i[1] = 16'd250; kp_i[1] = 16'h3000; ki_i[1] = 16'h0400;
    ref_i[2] = 16'd900; fb_i[2] = -16'sd50; kp_i[2] = 16'h2000; ki_i[2] = 16'h0200;
    e1 = model(1); e0 = model(0); e2 = model(2);
    @(negedge clk) start_i = 3'b110;
    @(negedge clk) start_i = '0;
    @(negedge clk);
    @(negedge clk) start_i = 3'b001;
    @(negedge clk) start_i = '0;
    wait_done(dv);
    chk("R6 first served", dv, 3'b010);
    chk("R6 d value", sx(y_o[1]), e1);
    wait_done(dv);
    chk("R6 late speed before q", dv, 3'b001);
    chk("R6 speed value", sx(y_o[0]), e0);
    wait_done(dv);
    chk("R6 q last", dv, 3'b100);
    chk("R6 q value", sx(y_o[2]), e2);

    // R8: clear
    @(negedge clk) start_i = 3'b001;
    @(negedge clk) start_i = '0;
    clr_i = 1'b1;
    @(negedge clk) clr_i = 1'b0;
    for (int k = 0; k < 3; k++) m_int[k] = 0;
    for (int k = 0; k < 3; k++) chk("R8 cleared output", y_o[k], 0);
    repeat (12) begin
      @(negedge clk);
      chk("R8 aborted no done", done_o, 0);
    end
    run1(0, "R8 fresh integrator");

    // R1 R2: seeded sweep over all loops
    for (int v = 0; v < 300; v++) begin
      int ch;
      logic [31:0] r;
      ch = int'(nxt() % 3);
      r = nxt(); ref_i[ch] = r[15:0]; fb_i[ch] = r[31:16];
      r = nxt();
      if (v % 2 == 0) begin
        kp_i[ch] = r[15:0]; ki_i[ch] = r[31:16];
      end else begin
        kp_i[ch] = 16'($signed(r[15:0]) >>> 4);
        ki_i[ch] = 16'($signed(r[31:16]) >>> 6);
      end
      r = nxt();
      init_i[ch] = r[15:0];
      spd_en_i = (r[18:16] != 3'd0);
      cur_en_i = (r[21:19] != 3'd0);
      if (v % 60 == 59) begin
        r = nxt();
        spd_hi_i = 16'(r[13:0]);  spd_lo_i = 16'(-$signed({2'b0, r[27:14]}));
        r = nxt();
        cur_hi_i = 16'(r[12:0]);  cur_lo_i = 16'(-$signed({3'b0, r[25:13]}));
      end
      run1(ch, "R1 R2 sweep");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule